// File: doc/BRIEF.md
# Periodic and One-Shot Timer Comparator Channel

This block is a single channel of a free-running timer. It watches a main count value supplied from outside and raises a one-cycle `fire` strobe when the count equals the channel's deadline. The channel keeps the deadline, a reload period, a periodic/one-shot mode bit and a one-time latch. While that latch is armed, the next comparator write in periodic mode also places the deadline. Writes come from a register front end as a data word with one strobe bit per byte.

In one-shot mode a write places the deadline directly. The channel fires once when the count reaches that deadline and then waits. In periodic mode a comparator write sets the period. The channel moves the deadline forward by whole periods so that it always lands ahead of the count, both after each expiry and whenever it is re-armed. That step needs the remainder of (count - deadline) divided by the period. An iterative divider produces it over `W` cycles, and the new deadline is then count - remainder + period. A period of zero in periodic mode behaves as one-shot.

A small state machine sequences the channel. ST_IDLE means no deadline is pending. ST_ARMED means the channel waits for a match. ST_CALC means the divider is computing the next deadline. The transitions are:
- stop: any state goes to ST_IDLE while `count_run` is low.
- rearm: a changed deadline or period, or a rising `count_run`, moves to ST_CALC when the mode is periodic with a non-zero period, and to ST_ARMED otherwise.
- match: ST_ARMED moves to ST_CALC or ST_IDLE by the same rule.
- reload: ST_CALC moves to ST_ARMED when the divider finishes, or at once if the channel left effective periodic operation.

Top module: `tmr_channel`

## Requirements
- R1: After reset the deadline is all ones, the period is zero, the mode is one-shot, the value-set latch is clear and `fire` is low.
- R2: In one-shot mode a comparator write replaces byte b of the deadline (bits 8b+7..8b) with the written byte wherever strobe bit b is 1, and keeps the period at zero.
- R3: In periodic mode a comparator write merges the data into the period by the same byte rule. The deadline takes the merged period only if the value-set latch was armed; otherwise the deadline is unchanged.
- R4: A configuration write with `cfg_valset`=1 arms the value-set latch, and every comparator write clears it in either mode.
- R5: Whenever the mode is one-shot (including after a configuration write selecting one-shot) the period reads zero.
- R6: In one-shot mode `fire` is high for exactly the cycle in which `count_run` is high, the channel is armed and `count_val` equals the deadline; afterwards it stays low even while the count holds that value.
- R7: In periodic mode with a non-zero period, an expiry moves the deadline to old deadline + period (modulo 2^W) within W+2 cycles, and the channel fires again at that value.
- R8: On re-arm (deadline or period changed while running, or `count_run` rising) in periodic mode, the deadline becomes c - ((c - d) mod p) + p modulo 2^W, where c is the count at re-arm, d the deadline and p the period. In one-shot mode re-arm only arms the channel.
- R9: One-shot mode does no catch-up. A deadline behind the count fires only when the count later equals it, and the deadline never changes without a write.
- R10: In periodic mode with a period of zero, the channel fires once and keeps its deadline, as in one-shot mode.
- R11: `fire` is never high while `count_run` is low.
- R12: A comparator write that leaves both deadline and period unchanged does not re-arm the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_run | input | 1 | Main counter is running |
| count_val | input | W | Current main count |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_periodic | input | 1 | Mode written by a configuration write (1 = periodic) |
| cfg_valset | input | 1 | Value-set latch written by a configuration write |
| cmp_we | input | 1 | Comparator write strobe |
| cmp_wdata | input | W | Comparator write data |
| cmp_wstrb | input | W/8 | Byte strobes for the comparator write |
| fire | output | 1 | One-cycle expiry strobe |
| cmp_value | output | W | Current deadline |
| period_value | output | W | Current period |
| periodic_mode | output | 1 | Mode bit |
| valset_armed | output | 1 | Value-set latch |
| reload_busy | output | 1 | Channel is computing the next deadline |

## Verification
The bench builds the channel with W = 16, so the divider needs 16 cycles per step and the byte strobes are two bits wide. At this width, random counts and deadlines wrap the modulo-2^16 arithmetic often. The catch-up formula is therefore exercised with deadlines both ahead of and behind the count, and with periods from one up to the full range. Directed cases add one-shot deadlines in the past, a zero period in periodic mode, unchanged rewrites and a restart of the counter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CALC  = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/tmr_bytemerge.sv
module tmr_bytemerge #(
    parameter int W = 32
) (
    input  logic [W-1:0]   old_val,
    input  logic [W-1:0]   wr_val,
    input  logic [W/8-1:0] wr_strb,
    output logic [W-1:0]   merged
);
    localparam int NB = W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign merged[8*b +: 8] = wr_strb[b] ? wr_val[8*b +: 8] : old_val[8*b +: 8];
    end
endmodule

// File: rtl/tmr_divrem.sv
module tmr_divrem #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    acc_q;
    logic [W-1:0]  dvd_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] step_q;
    logic          run_q;
    logic          done_q;
    logic [W:0]    trial;

    // restoring step: shift one dividend bit in, subtract if it fits
    assign trial = {acc_q[W-1:0], dvd_q[W-1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            dvd_q  <= '0;
            dvs_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                acc_q  <= '0;
                dvd_q  <= dividend;
                dvs_q  <= divisor;
                step_q <= CW'(W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                acc_q  <= (trial >= {1'b0, dvs_q}) ? trial - {1'b0, dvs_q} : trial;
                dvd_q  <= dvd_q << 1;
                step_q <= step_q - 1'b1;
                if (step_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign rem  = acc_q[W-1:0];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           count_run,
    input  logic [W-1:0]   count_val,
    input  logic           cfg_we,
    input  logic           cfg_periodic,
    input  logic           cfg_valset,
    input  logic           cmp_we,
    input  logic [W-1:0]   cmp_wdata,
    input  logic [W/8-1:0] cmp_wstrb,
    output logic           fire,
    output logic [W-1:0]   cmp_value,
    output logic [W-1:0]   period_value,
    output logic           periodic_mode,
    output logic           valset_armed,
    output logic           reload_busy
);
    tmr_state_e state_q, state_d;

    logic [W-1:0] cmp_q, per_q, base_q;
    logic         mode_q, vs_q, run_q;
    logic [W-1:0] mrg_cmp, mrg_per;
    logic [W-1:0] nxt_cmp, nxt_per;
    logic         nxt_mode, nxt_vs;
    logic         chg, rearm, nxt_eff, hit;
    logic         div_go, div_done, load_tgt;
    logic [W-1:0] div_dvd, div_rem, tgt;

    tmr_bytemerge #(.W(W)) u_mrg_cmp (
        .old_val(cmp_q), .wr_val(cmp_wdata), .wr_strb(cmp_wstrb), .merged(mrg_cmp)
    );

    tmr_bytemerge #(.W(W)) u_mrg_per (
        .old_val(per_q), .wr_val(cmp_wdata), .wr_strb(cmp_wstrb), .merged(mrg_per)
    );

    // register write semantics
    always_comb begin
        nxt_cmp  = cmp_q;
        nxt_per  = per_q;
        nxt_mode = mode_q;
        nxt_vs   = vs_q;
        if (cfg_we) begin
            nxt_mode = cfg_periodic;
            nxt_vs   = cfg_valset;
        end
        if (cmp_we) begin
            if (mode_q) begin
                nxt_per = mrg_per;
                if (vs_q) nxt_cmp = mrg_per;
            end else begin
                nxt_cmp = mrg_cmp;
            end
            nxt_vs = 1'b0;
        end
        if (!nxt_mode) nxt_per = '0;
    end

    assign chg     = cmp_we && ((nxt_cmp != cmp_q) || (nxt_per != per_q));
    assign rearm   = count_run && (chg || !run_q);
    assign nxt_eff = nxt_mode && (nxt_per != '0);
    assign hit     = count_run && (state_q == ST_ARMED) && (count_val == cmp_q);
    assign div_dvd = count_val - nxt_cmp;
    assign tgt     = base_q - div_rem + nxt_per;

    tmr_divrem #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_go),
        .dividend(div_dvd), .divisor(nxt_per),
        .done(div_done), .rem(div_rem)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        div_go   = 1'b0;
        load_tgt = 1'b0;
        if (!count_run) begin
            state_d = ST_IDLE;
        end else if (rearm) begin
            state_d = nxt_eff ? ST_CALC : ST_ARMED;
            div_go  = nxt_eff;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: begin
                    if (hit) begin
                        state_d = nxt_eff ? ST_CALC : ST_IDLE;
                        div_go  = nxt_eff;
                    end
                end
                ST_CALC: begin
                    if (!nxt_eff) begin
                        state_d = ST_ARMED;
                    end else if (div_done) begin
                        state_d  = ST_ARMED;
                        load_tgt = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // channel registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '1;
            per_q  <= '0;
            mode_q <= 1'b0;
            vs_q   <= 1'b0;
            run_q  <= 1'b0;
            base_q <= '0;
        end else begin
            cmp_q  <= load_tgt ? tgt : nxt_cmp;
            per_q  <= nxt_per;
            mode_q <= nxt_mode;
            vs_q   <= nxt_vs;
            run_q  <= count_run;
            if (div_go) base_q <= count_val;
        end
    end

    // outputs
    always_comb begin
        fire          = hit;
        reload_busy   = (state_q == ST_CALC);
        cmp_value     = cmp_q;
        period_value  = per_q;
        periodic_mode = mode_q;
        valset_armed  = vs_q;
    end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         count_run,
    input logic         cfg_we,
    input logic         cmp_we,
    input logic         fire,
    input logic [W-1:0] cmp_value,
    input logic [W-1:0] period_value,
    input logic         periodic_mode,
    input logic         valset_armed,
    input logic         reload_busy
);
    AST_NO_FIRE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !count_run |-> !fire); // R11

    AST_ONESHOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !periodic_mode && !cmp_we && !cfg_we) |=> !fire); // R6

    AST_ONESHOT_NO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !periodic_mode |-> (period_value == '0)); // R5

    AST_VALSET_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> !valset_armed); // R4

    AST_PERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_we && !cfg_we) |=> $stable(period_value)); // R3

    AST_RELOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && periodic_mode && (period_value != '0) && !cmp_we && !cfg_we) |=> reload_busy); // R7

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_we && !cfg_we && !periodic_mode) |=> $stable(cmp_value)); // R9
endmodule

bind tmr_channel tmr_channel_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .count_run(count_run), .cfg_we(cfg_we),
    .cmp_we(cmp_we), .fire(fire), .cmp_value(cmp_value),
    .period_value(period_value), .periodic_mode(periodic_mode),
    .valset_armed(valset_armed), .reload_busy(reload_busy)
);

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
    localparam int W  = 16;
    localparam int NB = W / 8;
    localparam int WAITC = W + 4;

    logic          clk = 1'b0;
    logic          rst_n, count_run, cfg_we, cfg_periodic, cfg_valset, cmp_we;
    logic [W-1:0]  count_val, cmp_wdata;
    logic [NB-1:0] cmp_wstrb;
    logic          fire, periodic_mode, valset_armed, reload_busy;
    logic [W-1:0]  cmp_value, period_value;

    int n_vec = 0;
    int n_bad = 0;

    logic [W-1:0] m_cmp, m_per, cnt;
    logic         m_mode;

    always #4 clk = ~clk;

    tmr_channel #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .count_run(count_run), .count_val(count_val),
        .cfg_we(cfg_we), .cfg_periodic(cfg_periodic), .cfg_valset(cfg_valset),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cmp_wstrb(cmp_wstrb),
        .fire(fire), .cmp_value(cmp_value), .period_value(period_value),
        .periodic_mode(periodic_mode), .valset_armed(valset_armed),
        .reload_busy(reload_busy)
    );

    function automatic logic [W-1:0] merge(logic [W-1:0] o, logic [W-1:0] d, logic [NB-1:0] s);
        logic [W-1:0] r = o;
        for (int b = 0; b < NB; b++) if (s[b]) r[8*b +: 8] = d[8*b +: 8];
        return r;
    endfunction

    function automatic logic [W-1:0] catchup(logic [W-1:0] c, logic [W-1:0] d, logic [W-1:0] p);
        logic [W-1:0] diff = c - d;
        logic [W-1:0] r = diff % p;
        return c - r + p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic setcnt(input logic [W-1:0] v);
        count_val = v;
        cnt = v;
        #1;
    endtask

    task automatic cmp_wr(input logic [W-1:0] d, input logic [NB-1:0] s);
        cmp_we = 1'b1; cmp_wdata = d; cmp_wstrb = s;
        step();
        cmp_we = 1'b0;
        #1;
    endtask

    task automatic cfg_wr(input logic per, input logic vs);
        cfg_we = 1'b1; cfg_periodic = per; cfg_valset = vs;
        step();
        cfg_we = 1'b0;
        #1;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] np, d;
        logic [NB-1:0] s;
        logic ch;
        rst_n = 1'b0; count_run = 1'b0; count_val = '0; cnt = '0;
        cfg_we = 1'b0; cfg_periodic = 1'b0; cfg_valset = 1'b0;
        cmp_we = 1'b0; cmp_wdata = '0; cmp_wstrb = '0;
        void'($urandom(32'd4711));
        settle(3);
        check("R1 cmp", cmp_value, 32'hFFFF);
        check("R1 period", period_value, 0);
        check("R1 mode", periodic_mode, 0);
        check("R1 valset", valset_armed, 0);
        check("R1 fire", fire, 0);
        rst_n = 1'b1;
        step();

        // one-shot
        setcnt(100); count_run = 1'b1; step();
        cmp_wr(105, '1);
        check("R2 cmp", cmp_value, 105);
        check("R2 period", period_value, 0);
        setcnt(104); check("R6 early", fire, 0);
        setcnt(105); check("R6 match", fire, 1);
        step();      check("R6 single", fire, 0);
        step();      check("R6 held", fire, 0);
        cmp_wr(105, '1); check("R12 same value", fire, 0);
        cmp_wr(50, '1);  check("R9 past", fire, 0);
        setcnt(200); check("R9 beyond", fire, 0);
        setcnt(50);  check("R9 wrap hit", fire, 1);
        step();

        // stopped counter
        count_run = 1'b0; step();
        cmp_wr(60, '1);
        setcnt(60); check("R11 stopped", fire, 0);
        step();     check("R11 stopped2", fire, 0);
        count_run = 1'b1; step();
        check("R8 oneshot restart", fire, 1);
        step();
        cmp_wr(16'hAB12, 2'b10);
        check("R2 byte strobe", cmp_value, 16'hAB3C);

        // periodic
        cfg_wr(1'b1, 1'b1);
        check("R4 armed", valset_armed, 1);
        setcnt(3);
        cmp_wr(10, '1);
        check("R3 period", period_value, 10);
        check("R3 valset load", cmp_value, 10);
        check("R4 cleared", valset_armed, 0);
        check("R8 busy", reload_busy, 1);
        settle(WAITC);
        m_cmp = catchup(3, 10, 10);
        check("R8 catch-up", cmp_value, m_cmp);
        setcnt(m_cmp); check("R7 fire", fire, 1);
        step(); settle(WAITC);
        check("R7 advance", cmp_value, m_cmp + 10);
        m_cmp = m_cmp + 10;
        setcnt(m_cmp); check("R7 refire", fire, 1);
        step(); settle(WAITC);
        check("R7 advance2", cmp_value, m_cmp + 10);
        m_cmp = m_cmp + 10;

        cmp_wr(7, '1);
        check("R3 no valset keeps cmp", cmp_value, m_cmp);
        settle(WAITC);
        m_cmp = catchup(cnt, m_cmp, 7);
        check("R3 rearm period", cmp_value, m_cmp);

        count_run = 1'b0; step();
        setcnt(m_cmp + 37);
        count_run = 1'b1; step();
        settle(WAITC);
        m_cmp = catchup(cnt, m_cmp, 7);
        check("R8 restart catch-up", cmp_value, m_cmp);

        // zero period in periodic mode
        cmp_wr(0, '1);
        check("R10 period zero", period_value, 0);
        check("R10 not busy", reload_busy, 0);
        setcnt(m_cmp); check("R10 fire", fire, 1);
        step();        check("R10 single", fire, 0);
        settle(WAITC); check("R10 cmp kept", cmp_value, m_cmp);

        cmp_wr(5, '1);
        settle(WAITC);
        m_cmp = catchup(cnt, m_cmp, 5);
        check("R8 period5", cmp_value, m_cmp);
        cfg_wr(1'b0, 1'b0);
        check("R5 period cleared", period_value, 0);
        check("R5 mode", periodic_mode, 0);
        m_mode = 1'b0; m_per = '0;

        // random mix
        for (int it = 0; it < 150; it++) begin
            int op;
            op = $urandom % 3;
            np = W'($urandom);
            if (np == m_cmp) np = np + 1'b1;
            setcnt(np);
            d = W'($urandom);
            s = NB'($urandom);
            if (op == 0) begin
                if (m_mode) begin cfg_wr(1'b0, 1'b0); m_mode = 1'b0; m_per = '0; end
                cmp_wr(d, s);
                m_cmp = merge(m_cmp, d, s);
                check("R2 rand cmp", cmp_value, m_cmp);
            end else if (op == 1) begin
                cfg_wr(1'b1, 1'b1); m_mode = 1'b1;
                np = ($urandom % 2) ? W'($urandom) : W'($urandom % 300);
                if (np == '0) np = 1;
                ch = (np != m_per) || (np != m_cmp);
                cmp_wr(np, '1);
                m_per = np; m_cmp = np;
                settle(WAITC);
                if (ch) m_cmp = catchup(cnt, m_cmp, m_per);
                check("R8 rand valset", cmp_value, m_cmp);
            end else begin
                cfg_wr(1'b1, 1'b0); m_mode = 1'b1;
                np = merge(m_per, d, s);
                ch = (np != m_per);
                cmp_wr(d, s);
                m_per = np;
                settle(WAITC);
                if (ch && np != '0) m_cmp = catchup(cnt, m_cmp, np);
                check("R3 rand period", cmp_value, m_cmp);
            end
            check("R5 rand period", period_value, m_per);
            check("R4 rand valset", valset_armed, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule